// File: doc/BRIEF.md
# Five-Stage In-Order Integer Pipeline

This block is a small 32-bit in-order processor that moves each instruction through five stages: fetch, decode with register read, execute, memory access and write-back. It runs a compact load/store integer subset: three register-to-register operations, two immediate operations, a word load, a word store and an equality branch. It has no forwarding network and no hazard detection. Software, or whatever generates the instruction stream, must space dependent instructions. Instructions are read from a synchronous instruction ROM. Load and store traffic goes to a synchronous data RAM that is read and written through a single port.

The instruction decoder runs once, in decode. It produces a packed bundle of strobes. That bundle then travels with its instruction through the pipeline registers. The execute group of strobes (immediate extension, operand select, ALU function, destination select) is used one cycle after decode. The store strobe drives the RAM two cycles after decode. The register-write and result-select strobes act three cycles after decode. The equality branch is resolved in decode, so exactly one instruction after it (the delay slot) always executes. The RAM's own output register serves as the loaded-word half of the memory/write-back stage, so a load's data is ready at write-back with no extra storage.

Top module: `pipe5_core`

## Requirements
- R1: While reset is held and immediately after it, the fetch address is 0, no store reaches the RAM, and every in-flight slot behaves as a no-op. On the first clock after reset is released, the fetch address becomes 4.
- R2: Register-to-register operations use primary opcode 0 and are selected by the low six bits of the word: 0x20 adds, 0x22 subtracts (rs minus rt), and 0x24 gives the bitwise AND. The result goes to the register in bits 15:11.
- R3: Immediate instructions write the register in bits 20:16. Opcode 0x08 adds a sign-extended 16-bit immediate. Opcode 0x0D ORs in a zero-extended immediate.
- R4: Opcode 0x23 loads a word and opcode 0x2B stores one. In both, the byte address is rs plus the sign-extended immediate. A store writes the value of the register in bits 20:16, and a load writes the word it reads into that register.
- R5: Opcode 0x04 compares rs and rt. When they are equal, the instruction fetched after the delay slot comes from (branch address + 4) + 4 × sign-extended immediate. The delay-slot instruction always executes, and the instructions skipped over have no effect.
- R6: An untaken branch, or any other instruction, lets fetch continue sequentially, with the address rising by 4 each cycle.
- R7: A result is written in its write-back cycle and is seen by an instruction decoded in that same cycle, which is three slots after the producer. An instruction decoded two slots after the producer reads the stale value, because nothing is forwarded.
- R8: No load-use interlock exists. The instruction right after a load reads the register's previous contents.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: The all-zero word, any unlisted opcode and any unlisted function code act as no-ops: they write no register, store nothing and do not branch.
- R11: A store's RAM write strobe appears exactly two cycles after the store was decoded. A register write happens exactly three cycles after its instruction was decoded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| imemAddr | output | 32 | Byte address of the instruction being fetched |
| imemData | input | 32 | Instruction word returned by the synchronous ROM one cycle after its address |
| dmemAddr | output | 32 | Byte address of the load or store now in the memory stage |
| dmemWrEn | output | 1 | Store strobe for the data RAM |
| dmemWrData | output | 32 | Data to store |
| dmemRdData | input | 32 | Word read by the synchronous RAM, registered at the end of the memory stage |

## Verification
Assertions check the stage timing of the strobes on every cycle. A RAM write must trace back to a store decoded two cycles earlier, and a register write to a writing instruction decoded three cycles earlier. The same assertions check that the fetch address advances by 4, or jumps to the computed target after a taken branch, and that an all-zero slot raises no strobe. The arithmetic results, the sign and zero extension, the delay slot and the skipped instructions can only be shown by the bench's program. So can the stale reads at distances one and two, and the same-cycle write-then-read at distance three. The program writes each result to data memory with a store, where it is compared with values worked out by hand from the delayed-branch rules.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int XLEN    = 32;
  localparam int REG_CNT = 32;
  localparam int RIDX_W  = $clog2(REG_CNT);
  localparam int IMM_W   = 16;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_ORI   = 6'h0D;
  localparam logic [5:0] OP_LW    = 6'h23;
  localparam logic [5:0] OP_SW    = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;

  typedef enum logic [1:0] {
    ALU_ADD = 2'd0,
    ALU_SUB = 2'd1,
    ALU_AND = 2'd2,
    ALU_OR  = 2'd3
  } aluOp_e;

  // Strobes produced once in decode and carried with the instruction.
  typedef struct packed {
    logic   regWr;      // write-back group
    logic   memToReg;   // write-back group
    logic   memWr;      // memory group
    logic   branch;     // used in decode
    logic   regDstRd;   // execute group
    logic   aluSrcImm;  // execute group
    logic   extSign;    // execute group
    aluOp_e aluOp;      // execute group
  } ctrl_t;
endpackage

// File: rtl/pipe5_ctrl.sv
module pipe5_ctrl
  import pipe5_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.regDstRd = 1'b1;
        unique case (funct)
          FN_ADD:  begin ctrl.regWr = 1'b1; ctrl.aluOp = ALU_ADD; end
          FN_SUB:  begin ctrl.regWr = 1'b1; ctrl.aluOp = ALU_SUB; end
          FN_AND:  begin ctrl.regWr = 1'b1; ctrl.aluOp = ALU_AND; end
          default: ctrl = '0;
        endcase
      end
      OP_ADDI: begin
        ctrl.regWr = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.extSign = 1'b1;
        ctrl.aluOp = ALU_ADD;
      end
      OP_ORI: begin
        ctrl.regWr = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.extSign = 1'b0;
        ctrl.aluOp = ALU_OR;
      end
      OP_LW: begin
        ctrl.regWr = 1'b1; ctrl.memToReg = 1'b1; ctrl.aluSrcImm = 1'b1;
        ctrl.extSign = 1'b1; ctrl.aluOp = ALU_ADD;
      end
      OP_SW: begin
        ctrl.memWr = 1'b1; ctrl.aluSrcImm = 1'b1; ctrl.extSign = 1'b1;
        ctrl.aluOp = ALU_ADD;
      end
      OP_BEQ:  ctrl.branch = 1'b1;
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/pipe5_datapath.sv
module pipe5_datapath
  import pipe5_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  ctrl_t           ctrl,
  output logic [XLEN-1:0] decInstr,
  output logic [XLEN-1:0] imemAddr,
  input  logic [XLEN-1:0] imemData,
  output logic [XLEN-1:0] dmemAddr,
  output logic            dmemWrEn,
  output logic [XLEN-1:0] dmemWrData,
  input  logic [XLEN-1:0] dmemRdData
);
  localparam int EXT_W = XLEN - IMM_W;

  // ---------------- fetch / decode ----------------
  logic [XLEN-1:0] fetchPc;
  logic            decValid;
  logic [RIDX_W-1:0] rs, rt, rd;
  logic [IMM_W-1:0]  imm;
  logic [XLEN-1:0] rdA, rdB, immSext, branchTarget;
  logic            branchTaken;

  // write-back side, declared early for the register file read path
  logic              wbRegWr, wbMemToReg;
  logic [XLEN-1:0]   wbAlu, wbData;
  logic [RIDX_W-1:0] wbDest;

  assign imemAddr = fetchPc;
  assign decInstr = decValid ? imemData : '0;
  assign rs  = decInstr[25:21];
  assign rt  = decInstr[20:16];
  assign rd  = decInstr[15:11];
  assign imm = decInstr[IMM_W-1:0];

  // register file: one flop bank per entry, entry 0 is hard zero
  logic [XLEN-1:0] regs [REG_CNT];
  for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign regs[g] = '0;
    end else begin : g_flop
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) regs[g] <= '0;
        else if (wbRegWr && wbDest == RIDX_W'(g)) regs[g] <= wbData;
      end
    end
  end

  // write-first read: a same-cycle write-back is visible in decode
  always_comb begin
    if (rs == '0)                        rdA = '0;
    else if (wbRegWr && wbDest == rs)    rdA = wbData;
    else                                 rdA = regs[rs];
  end
  always_comb begin
    if (rt == '0)                        rdB = '0;
    else if (wbRegWr && wbDest == rt)    rdB = wbData;
    else                                 rdB = regs[rt];
  end

  assign immSext      = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign branchTarget = fetchPc + (immSext << 2);
  assign branchTaken  = ctrl.branch && (rdA == rdB);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPc  <= RESET_PC;
      decValid <= 1'b0;
    end else begin
      fetchPc  <= branchTaken ? branchTarget : fetchPc + XLEN'(4);
      decValid <= 1'b1;
    end
  end

  // ---------------- decode -> execute ----------------
  ctrl_t             exCtrl;
  logic [XLEN-1:0]   exA, exB;
  logic [IMM_W-1:0]  exImm;
  logic [RIDX_W-1:0] exRt, exRd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exCtrl <= '0; exA <= '0; exB <= '0; exImm <= '0; exRt <= '0; exRd <= '0;
    end else begin
      exCtrl <= ctrl; exA <= rdA; exB <= rdB; exImm <= imm; exRt <= rt; exRd <= rd;
    end
  end

  logic [XLEN-1:0]   exImmExt, exOpB, exAlu;
  logic [RIDX_W-1:0] exDest;
  assign exImmExt = exCtrl.extSign ? {{EXT_W{exImm[IMM_W-1]}}, exImm}
                                   : {{EXT_W{1'b0}}, exImm};
  assign exOpB    = exCtrl.aluSrcImm ? exImmExt : exB;
  assign exDest   = exCtrl.regDstRd ? exRd : exRt;

  always_comb begin
    unique case (exCtrl.aluOp)
      ALU_ADD: exAlu = exA + exOpB;
      ALU_SUB: exAlu = exA - exOpB;
      ALU_AND: exAlu = exA & exOpB;
      ALU_OR:  exAlu = exA | exOpB;
      default: exAlu = '0;
    endcase
  end

  // ---------------- execute -> memory ----------------
  logic              memRegWr, memMemToReg, memMemWr;
  logic [XLEN-1:0]   memAlu, memStore;
  logic [RIDX_W-1:0] memDest;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memRegWr <= 1'b0; memMemToReg <= 1'b0; memMemWr <= 1'b0;
      memAlu <= '0; memStore <= '0; memDest <= '0;
    end else begin
      memRegWr    <= exCtrl.regWr && (exDest != '0);
      memMemToReg <= exCtrl.memToReg;
      memMemWr    <= exCtrl.memWr;
      memAlu      <= exAlu;
      memStore    <= exB;
      memDest     <= exDest;
    end
  end

  assign dmemAddr   = memAlu;
  assign dmemWrEn   = memMemWr;
  assign dmemWrData = memStore;

  // ---------------- memory -> write-back ----------------
  // The loaded word half of this stage is the RAM's own output register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbRegWr <= 1'b0; wbMemToReg <= 1'b0; wbAlu <= '0; wbDest <= '0;
    end else begin
      wbRegWr <= memRegWr; wbMemToReg <= memMemToReg; wbAlu <= memAlu; wbDest <= memDest;
    end
  end

  assign wbData = wbMemToReg ? dmemRdData : wbAlu;

  // ---------------- assertions ----------------
  p_store_lag_r11: assert property (@(posedge clk) disable iff (!rstN)
    dmemWrEn |-> $past(ctrl.memWr, 2))
    else $error("store strobe without a store decoded two cycles earlier");

  p_regwr_lag_r11: assert property (@(posedge clk) disable iff (!rstN)
    wbRegWr |-> $past(ctrl.regWr, 3))
    else $error("register write without a writer decoded three cycles earlier");

  p_branch_pc_r5: assert property (@(posedge clk) disable iff (!rstN)
    branchTaken |=> imemAddr == $past(fetchPc) + ($past(immSext) << 2))
    else $error("taken branch did not redirect fetch");

  p_seq_pc_r6: assert property (@(posedge clk) disable iff (!rstN)
    !branchTaken |=> imemAddr == $past(imemAddr) + XLEN'(4))
    else $error("sequential fetch did not advance by 4");

  p_zero_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (decInstr == '0) |-> !(ctrl.regWr || ctrl.memWr || ctrl.branch))
    else $error("no-op slot raised a strobe");
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  output logic [XLEN-1:0] imemAddr,
  input  logic [XLEN-1:0] imemData,
  output logic [XLEN-1:0] dmemAddr,
  output logic            dmemWrEn,
  output logic [XLEN-1:0] dmemWrData,
  input  logic [XLEN-1:0] dmemRdData
);
  ctrl_t           ctrl;
  logic [XLEN-1:0] decInstr;

  pipe5_ctrl ctrl_i (
    .opcode (decInstr[31:26]),
    .funct  (decInstr[5:0]),
    .ctrl   (ctrl)
  );

  pipe5_datapath dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .decInstr   (decInstr),
    .imemAddr   (imemAddr),
    .imemData   (imemData),
    .dmemAddr   (dmemAddr),
    .dmemWrEn   (dmemWrEn),
    .dmemWrData (dmemWrData),
    .dmemRdData (dmemRdData)
  );
endmodule

// File: tb/pipe5_core_tb_top.sv
module pipe5_core_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] imemAddr, imemData, dmemAddr, dmemWrData, dmemRdData;
  logic        dmemWrEn;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  pipe5_core dut_i (
    .clk(clk), .rstN(rstN),
    .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrEn(dmemWrEn),
    .dmemWrData(dmemWrData), .dmemRdData(dmemRdData)
  );

  // synchronous memories owned by the bench
  logic [31:0] rom [256];
  logic [31:0] ram [64];
  always_ff @(posedge clk) imemData <= rom[imemAddr[9:2]];
  always_ff @(posedge clk) begin
    if (dmemWrEn) ram[dmemAddr[7:2]] <= dmemWrData;
    dmemRdData <= ram[dmemAddr[7:2]];
  end

  function automatic logic [31:0] encI(logic [5:0] op, logic [4:0] rs, logic [4:0] rt,
                                       logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] encR(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd,
                                       logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic chk(input logic [23:0] tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // result table: RAM word index, expected value, requirement
  localparam int NVEC = 18;
  localparam logic [5:0] VEC_IDX [NVEC] = '{
    6'd16, 6'd17, 6'd18, 6'd19, 6'd20, 6'd21, 6'd22, 6'd23, 6'd24,
    6'd25, 6'd26, 6'd27, 6'd28, 6'd29, 6'd30, 6'd31, 6'd1, 6'd2};
  localparam logic [31:0] VEC_EXP [NVEC] = '{
    32'h0000_0005, 32'hFFFF_0FF8, 32'h0000_1230, 32'hFFFF_FFFF, 32'h0000_1200,
    32'h0000_0011, 32'h0000_0000, 32'h0000_0044, 32'h0000_0055, 32'h0000_0066,
    32'h0000_0000, 32'h0000_1234, 32'h0000_0000, 32'h0000_005A, 32'h0000_0000,
    32'h0000_0000, 32'hFFFF_FFF0, 32'h0000_1234};
  localparam logic [23:0] VEC_TAG [NVEC] = '{
    "R2 ", "R2 ", "R4 ", "R3 ", "R3 ", "R5 ", "R5 ", "R6 ", "R6 ",
    "R6 ", "R9 ", "R4 ", "R8 ", "R7 ", "R7 ", "R10", "R4 ", "R4 "};

  initial begin
    for (int i = 0; i < 256; i++) rom[i] = '0;
    for (int i = 0; i < 64; i++)  ram[i] = 32'hDEAD_0000 + i;
    ram[1] = 32'hFFFF_FFF0;
    ram[2] = 32'h0000_1234;
    rom[0]  = encI(6'h08, 0, 1, 16'd7);          // r1 = 7
    rom[1]  = encI(6'h0D, 0, 2, 16'hF00F);       // r2 = 0xF00F (zero-ext)
    rom[2]  = encI(6'h08, 0, 3, 16'hFFFE);       // r3 = -2 (sign-ext)
    rom[3]  = encI(6'h23, 0, 4, 16'd4);          // r4 = mem[4]
    rom[4]  = encI(6'h23, 0, 5, 16'd8);          // r5 = mem[8]
    rom[5]  = encR(1, 1, 24, 6'h25);             // unlisted funct: no-op
    rom[6]  = encR(1, 3, 6, 6'h20);              // r6 = 5
    rom[7]  = encR(1, 2, 7, 6'h22);              // r7 = 7 - 0xF00F
    rom[8]  = encR(4, 5, 8, 6'h24);              // r8 = 0x1230
    rom[9]  = encI(6'h0D, 3, 9, 16'h00FF);       // r9 = all ones
    rom[10] = encI(6'h08, 5, 10, 16'hFFCC);      // r10 = 0x1200
    rom[11] = encI(6'h2B, 0, 6, 16'd64);
    rom[12] = encI(6'h2B, 0, 7, 16'd68);
    rom[13] = encI(6'h2B, 0, 8, 16'd72);
    rom[14] = encI(6'h2B, 0, 9, 16'd76);
    rom[15] = encI(6'h2B, 0, 10, 16'd80);
    rom[16] = encI(6'h04, 1, 1, 16'd3);          // taken -> index 20
    rom[17] = encI(6'h08, 0, 11, 16'h11);        // delay slot
    rom[18] = encI(6'h08, 0, 12, 16'h22);        // skipped
    rom[19] = encI(6'h08, 0, 12, 16'h33);        // skipped
    rom[20] = encI(6'h04, 1, 2, 16'd2);          // not taken
    rom[21] = encI(6'h08, 0, 13, 16'h44);        // delay slot
    rom[22] = encI(6'h08, 0, 14, 16'h55);
    rom[23] = encI(6'h08, 0, 15, 16'h66);
    rom[24] = encI(6'h2B, 0, 11, 16'd84);
    rom[25] = encI(6'h2B, 0, 12, 16'd88);
    rom[26] = encI(6'h2B, 0, 13, 16'd92);
    rom[27] = encI(6'h2B, 0, 14, 16'd96);
    rom[28] = encI(6'h2B, 0, 15, 16'd100);
    rom[29] = encI(6'h08, 0, 0, 16'h77);         // write to r0 discarded
    rom[32] = encI(6'h2B, 0, 0, 16'd104);
    rom[33] = encI(6'h23, 0, 16, 16'd8);         // r16 = 0x1234
    rom[34] = encR(16, 0, 17, 6'h20);            // load slot: reads old r16
    rom[35] = encI(6'h08, 0, 18, 16'h5A);
    rom[38] = encR(18, 0, 19, 6'h20);            // distance 3: sees 0x5A
    rom[39] = encI(6'h08, 0, 20, 16'd3);
    rom[41] = encR(20, 0, 21, 6'h20);            // distance 2: stale
    rom[42] = encI(6'h2B, 0, 16, 16'd108);
    rom[43] = encI(6'h2B, 0, 17, 16'd112);
    rom[44] = encI(6'h2B, 0, 19, 16'd116);
    rom[45] = encI(6'h2B, 0, 21, 16'd120);
    rom[46] = encI(6'h2B, 0, 24, 16'd124);
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 ", imemAddr, 32'h0);
    chk("R1 ", {31'd0, dmemWrEn}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ", imemAddr, 32'h4);
    repeat (120) @(negedge clk);
    for (int v = 0; v < NVEC; v++) chk(VEC_TAG[v], ram[VEC_IDX[v]], VEC_EXP[v]);
    // R1: reset in mid-flight returns to the start with no stores
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 ", imemAddr, 32'h0);
    chk("R1 ", {31'd0, dmemWrEn}, 32'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule